// File: doc/BRIEF.md
# HALT and SLEEP Standby Controller

This block decides when the processor core and the peripheral logic receive clocks while the chip moves between normal operation and two standby levels. A light standby level (HALT) stops only the core clock, so timers and serial logic keep running. A deep standby level (SLEEP) stops both clocks on the assumption that the oscillator itself is halted. Both levels are requested by one-cycle strobes that the core raises when it executes the matching instruction.

The two levels differ in what brings the chip back. The light level returns to running on any interrupt request, and the clocks come back in the very next cycle. The deep level ignores every interrupt except one from the input port, and it then waits a fixed number of slow-clock cycles so the oscillator can settle before any clock is enabled again. On either interrupt-driven return, a one-cycle strobe tells the core to enter its exception routine. A synchronous reset overrides everything and returns the block to running at once, with no settling wait and no strobe.

The whole block runs on the slow oscillator clock. The settling length is a parameter whose default is 8192 cycles.

Top module: `standby_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to the running state after that edge: `cpu_clk_en`=1, `per_clk_en`=1, `wake_exc`=0, and this holds whatever state it was in, including the middle or the last cycle of the settling wait.
- R2: In the running state, `halt_req`=1 with `sleep_req`=0 moves the block to HALT after the edge: `cpu_clk_en`=0, `per_clk_en`=1.
- R3: In HALT, `irq_any`=1 or `irq_port`=1 at an edge returns the block to running after that edge, with `cpu_clk_en`=1, `per_clk_en`=1 and `wake_exc`=1 in that same cycle.
- R4: In the running state, `sleep_req`=1 moves the block to SLEEP after the edge, with `cpu_clk_en`=0 and `per_clk_en`=0; when `halt_req` and `sleep_req` are both 1 in one cycle, SLEEP is taken.
- R5: In SLEEP, `irq_any` without `irq_port` has no effect: both enables stay 0 and `wake_exc` stays 0.
- R6: In SLEEP, `irq_port`=1 at an edge starts the settling wait; both enables stay 0 for exactly SETTLE_CYCLES cycles after that edge (8191 further edges at the default), and after the 8192nd edge both enables become 1 in the same cycle together with `wake_exc`=1.
- R7: The settling counter is cleared on each SLEEP entry, so every deep wake waits the full SETTLE_CYCLES cycles, even after a wait that was cut short by reset.
- R8: `wake_exc` is high for exactly one cycle per wake and is never high in a cycle that follows a running cycle.
- R9: `cpu_clk_en` is never 1 while `per_clk_en` is 0.
- R10: In the running state, `irq_any` and `irq_port` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Strobe from the core: enter light standby |
| sleep_req | input | 1 | Strobe from the core: enter deep standby |
| irq_any | input | 1 | Some enabled interrupt request is pending |
| irq_port | input | 1 | An input-port interrupt request is pending |
| cpu_clk_en | output | 1 | Clock enable for the processor core |
| per_clk_en | output | 1 | Clock enable for the peripheral logic |
| wake_exc | output | 1 | One-cycle strobe: resume through the exception routine |

## Verification
Two pairs of functions can meet in one cycle here. Reset can arrive in the very cycle the settling wait completes, which the bench provokes by counting 8191 edges after the port interrupt and then raising reset; the result must be the running state without the wake strobe, and a following deep standby must again wait the full count. The two standby requests can also arrive together, and the bench raises both in one cycle and judges by the peripheral enable, which must drop, showing that the deep level won.

// File: rtl/standby_pkg.sv
package standby_pkg;

    localparam int SETTLE_DEFAULT = 8192;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_SETTLE = 2'd3
    } sb_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
    } clk_en_t;

    // Clock enables implied by each state.
    function automatic clk_en_t enables_of(sb_state_e st);
        clk_en_t e;
        case (st)
            ST_RUN:  e = '{cpu: 1'b1, per: 1'b1};
            ST_HALT: e = '{cpu: 1'b0, per: 1'b1};
            default: e = '{cpu: 1'b0, per: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYCLES = 8192,
    localparam int CNT_W = $clog2(SETTLE_CYCLES)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic count_en,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = count_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (count_en && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/standby_seq.sv
module standby_seq
    import standby_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      halt_req,
    input  logic      sleep_req,
    input  logic      irq_any,
    input  logic      irq_port,
    input  logic      settle_done,
    output sb_state_e state,
    output logic      clear_cnt,
    output logic      count_en,
    output logic      wake
);
    sb_state_e state_nx;
    logic      wake_nx;

    always_comb begin
        state_nx  = state;
        wake_nx   = 1'b0;
        clear_cnt = 1'b0;
        case (state)
            ST_RUN: begin
                if (sleep_req) begin
                    state_nx  = ST_SLEEP;
                    clear_cnt = 1'b1;
                end else if (halt_req) begin
                    state_nx = ST_HALT;
                end
            end
            ST_HALT: begin
                if (irq_any || irq_port) begin
                    state_nx = ST_RUN;
                    wake_nx  = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (irq_port) begin
                    state_nx = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    state_nx = ST_RUN;
                    wake_nx  = 1'b1;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    assign count_en = (state == ST_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            wake  <= 1'b0;
        end else begin
            state <= state_nx;
            wake  <= wake_nx;
        end
    end
endmodule

// File: rtl/clk_gate_decode.sv
module clk_gate_decode
    import standby_pkg::*;
(
    input  sb_state_e state,
    output logic      cpu_en,
    output logic      per_en
);
    clk_en_t en;

    always_comb begin
        en     = enables_of(state);
        cpu_en = en.cpu;
        per_en = en.per;
    end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import standby_pkg::*;
#(
    parameter int SETTLE_CYCLES = SETTLE_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic sleep_req,
    input  logic irq_any,
    input  logic irq_port,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic wake_exc
);
    sb_state_e cur_state;
    logic      clear_cnt;
    logic      count_en;
    logic      settle_done;

    standby_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .halt_req    (halt_req),
        .sleep_req   (sleep_req),
        .irq_any     (irq_any),
        .irq_port    (irq_port),
        .settle_done (settle_done),
        .state       (cur_state),
        .clear_cnt   (clear_cnt),
        .count_en    (count_en),
        .wake        (wake_exc)
    );

    settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear_cnt),
        .count_en (count_en),
        .done     (settle_done)
    );

    clk_gate_decode u_dec (
        .state  (cur_state),
        .cpu_en (cpu_clk_en),
        .per_en (per_clk_en)
    );
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk
    import standby_pkg::*;
#(
    parameter int SETTLE_CYCLES = SETTLE_DEFAULT,
    localparam int CNT_W = $clog2(SETTLE_CYCLES)
) (
    input logic      clk,
    input logic      rst,
    input logic      halt_req,
    input logic      sleep_req,
    input logic      irq_any,
    input logic      irq_port,
    input logic      cpu_clk_en,
    input logic      per_clk_en,
    input logic      wake_exc,
    input sb_state_e cur_state
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    // Independent count of cycles spent in the settling wait.
    logic [CNT_W-1:0] wait_cyc;
    always_ff @(posedge clk) begin
        if (rst || cur_state != ST_SETTLE) wait_cyc <= '0;
        else if (wait_cyc != LAST) wait_cyc <= wait_cyc + 1'b1;
    end

    p_reset_run_r1: assert property (@(posedge clk)
        rst |=> (cpu_clk_en && per_clk_en && !wake_exc));

    p_halt_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && halt_req && !sleep_req) |=> (!cpu_clk_en && per_clk_en));

    p_halt_wake_r3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && per_clk_en && (irq_any || irq_port)) |=> (cpu_clk_en && wake_exc));

    p_sleep_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && sleep_req) |=> (!cpu_clk_en && !per_clk_en));

    p_sleep_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_SLEEP && !irq_port) |=> (cur_state == ST_SLEEP && !per_clk_en && !wake_exc));

    p_settle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_SETTLE && wait_cyc != LAST) |=> (!cpu_clk_en && !per_clk_en));

    p_settle_done_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_SETTLE && wait_cyc == LAST) |=> (cpu_clk_en && per_clk_en && wake_exc));

    p_sleep_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_SLEEP && irq_port) |=> (cur_state == ST_SETTLE && wait_cyc == '0));

    p_wake_single_r8: assert property (@(posedge clk) disable iff (rst)
        wake_exc |=> !wake_exc);

    p_no_wake_after_run_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |=> (!wake_exc || !$past(cpu_clk_en)));

    p_enable_order_r9: assert property (@(posedge clk) disable iff (rst)
        !per_clk_en |-> !cpu_clk_en);

    p_run_irq_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && !halt_req && !sleep_req) |=> (cpu_clk_en && !wake_exc));
endmodule

bind standby_ctrl standby_ctrl_chk #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .sleep_req  (sleep_req),
    .irq_any    (irq_any),
    .irq_port   (irq_port),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .wake_exc   (wake_exc),
    .cur_state  (cur_state)
);

// File: tb/tb_standby_ctrl.sv
`timescale 1ns/1ps
module tb_standby_ctrl;
    localparam int SETTLE = 8192;
    localparam int WATCHDOG_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst, halt_req, sleep_req, irq_any, irq_port;
    logic cpu_clk_en, per_clk_en, wake_exc;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    standby_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .halt_req   (halt_req),
        .sleep_req  (sleep_req),
        .irq_any    (irq_any),
        .irq_port   (irq_port),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .wake_exc   (wake_exc)
    );

    // Advance one edge; inputs change and outputs are sampled 1 ns after it.
    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // exp/act packed as {cpu_clk_en, per_clk_en, wake_exc}
    task automatic expect_out(string req, string what, logic [2:0] exp);
        logic [2:0] act;
        act = {cpu_clk_en, per_clk_en, wake_exc};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: cpu/per/wake actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; halt_req = 0; sleep_req = 0; irq_any = 0; irq_port = 0;
        step(2);
        expect_out("R1", "reset state", 3'b110);
        rst = 1'b0;
        step();
        expect_out("R1", "running after reset", 3'b110);
    endtask

    task automatic t_run_irq_ignored();
        irq_any = 1'b1; irq_port = 1'b1;
        step();
        expect_out("R10", "interrupts while running", 3'b110);
        step();
        expect_out("R10", "interrupts held while running", 3'b110);
        irq_any = 1'b0; irq_port = 1'b0;
    endtask

    task automatic t_halt_any();
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        expect_out("R2", "halt entry", 3'b010);
        step(3);
        expect_out("R2", "halt held without interrupt", 3'b010);
        irq_any = 1'b1;
        step();
        irq_any = 1'b0;
        expect_out("R3", "halt wake on any interrupt", 3'b111);
        step();
        expect_out("R8", "wake strobe one cycle", 3'b110);
    endtask

    task automatic t_halt_port();
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        expect_out("R2", "halt entry again", 3'b010);
        irq_port = 1'b1;
        step();
        irq_port = 1'b0;
        expect_out("R3", "halt wake on port interrupt", 3'b111);
        step();
        expect_out("R8", "port wake strobe one cycle", 3'b110);
    endtask

    task automatic t_sleep_full();
        pulse_sleep();
        expect_out("R4", "sleep entry", 3'b000);
        irq_any = 1'b1;
        step(3);
        irq_any = 1'b0;
        expect_out("R5", "non-port interrupt ignored in sleep", 3'b000);
        irq_port = 1'b1;
        step();
        irq_port = 1'b0;
        expect_out("R6", "settling started", 3'b000);
        step(SETTLE - 1);
        expect_out("R6", "still settling at 8191 edges", 3'b000);
        step();
        expect_out("R6", "wake after 8192 edges", 3'b111);
        step();
        expect_out("R8", "deep wake strobe one cycle", 3'b110);
    endtask

    task automatic t_both_requests();
        halt_req = 1'b1; sleep_req = 1'b1;
        step();
        halt_req = 1'b0; sleep_req = 1'b0;
        expect_out("R4", "sleep wins over halt", 3'b000);
        irq_any = 1'b1;
        step();
        irq_any = 1'b0;
        expect_out("R5", "no halt-style wake", 3'b000);
        do_reset();
        expect_out("R1", "reset leaves sleep", 3'b110);
    endtask

    task automatic t_reset_mid_settle();
        pulse_sleep();
        irq_port = 1'b1;
        step();
        irq_port = 1'b0;
        step(100);
        expect_out("R6", "mid settling", 3'b000);
        do_reset();
        expect_out("R1", "reset during settling", 3'b110);
        // A new deep standby must wait the full count again.
        pulse_sleep();
        irq_port = 1'b1;
        step();
        irq_port = 1'b0;
        step(SETTLE - 1);
        expect_out("R7", "full wait after interrupted one", 3'b000);
        step();
        expect_out("R7", "wake after full wait", 3'b111);
        step();
    endtask

    task automatic t_reset_at_last();
        pulse_sleep();
        irq_port = 1'b1;
        step();
        irq_port = 1'b0;
        step(SETTLE - 1);
        expect_out("R6", "last settling cycle", 3'b000);
        do_reset();
        expect_out("R1", "reset wins on final settle cycle", 3'b110);
        step();
        expect_out("R8", "no late strobe after reset", 3'b110);
    endtask

    initial begin
        t_reset();
        t_run_irq_ignored();
        t_halt_any();
        t_halt_port();
        t_sleep_full();
        t_both_requests();
        t_reset_mid_settle();
        t_reset_at_last();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule